// File: doc/BRIEF.md
# Byte-Predicate Bitmask Packer

This block condenses four 128-bit predicate vectors into a single 64-bit bitmask. Each input byte is a saturated predicate, either 0xFF for true or 0x00 for false, produced upstream by byte-wise compares or class lookups. The output puts the predicate of byte k of the 64-byte block at bit k, whatever arrangement the bytes arrived in.

Two input arrangements are accepted, chosen per transfer by a layout select. In the consecutive arrangement each vector carries sixteen adjacent bytes. In the interleaved arrangement, which is what a four-way de-interleaving load delivers, each vector carries every fourth byte. For the consecutive arrangement each byte is masked to a one-hot bit and the block is narrowed by three pairwise byte-add stages. For the interleaved arrangement the four vectors are masked with alternating nibble patterns and merged into one 16-byte accumulator, and a single pairwise-add stage then produces the mask. The result is registered, and the layout select is captured in the same cycle as the data.

Top module: `mskpk_top`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and mask_o is all zeros.
- R2: valid_o is high exactly in the cycle after a cycle in which valid_i was high. The mask presented then is built from the vectors and the layout_i value sampled in that earlier cycle.
- R3: When valid_i is low, mask_o keeps its previous value whatever the other inputs carry.
- R4: With layout_i = 0 (consecutive), bit 16*j+i of mask_o is 1 exactly when byte i of vec<j>_i is 0xFF. Byte i occupies bits 8*i+7 down to 8*i.
- R5: With layout_i = 1 (interleaved), bit k of mask_o is 1 exactly when byte (k div 4) of vec<k mod 4>_i is 0xFF.
- R6: In either layout the number of set bits in mask_o equals the number of 0xFF bytes across the four input vectors.
- R7: All-zero inputs give mask_o = 0 and all-0xFF inputs give mask_o = all ones, in both layouts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input vectors and layout select are valid this cycle |
| layout_i | input | 1 | 0: consecutive layout, 1: interleaved layout |
| vec0_i | input | 128 | Predicate vector 0 |
| vec1_i | input | 128 | Predicate vector 1 |
| vec2_i | input | 128 | Predicate vector 2 |
| vec3_i | input | 128 | Predicate vector 3 |
| valid_o | output | 1 | mask_o was loaded in the previous cycle |
| mask_o | output | 64 | Packed bitmask, bit k for byte k |

## Verification
The bench walks a single true byte through all 64 positions in both layouts. A design that swaps the lane and vector roles of the interleave, or uses the wrong nibble of the alternating mask, sets the wrong bit, and a narrowing stage that pairs the wrong bytes scrambles groups of eight. All-zero and all-true blocks catch masks that leak extra bits or carries between neighbouring bytes. Random blocks sent back to back with alternating layouts catch a layout select that is sampled a cycle late. Idle cycles with changing data catch a register that loads without valid_i.

// File: rtl/mskpk_pkg.sv
package mskpk_pkg;
  typedef enum logic {
    LAYOUT_CONSEC = 1'b0,
    LAYOUT_ILV    = 1'b1
  } layout_e;

  localparam int unsigned NUM_VEC = 4;
  localparam int unsigned BYTE_W  = 8;
endpackage

// File: rtl/mskpk_pair_add.sv
module mskpk_pair_add #(
  parameter int unsigned OUT_BYTES = 8
) (
  input  logic [2*OUT_BYTES*8-1:0] din_i,
  output logic [OUT_BYTES*8-1:0]   dout_o
);
  // byte m of the result = byte 2m + byte 2m+1 of the input, modulo 256
  for (genvar m = 0; m < OUT_BYTES; m++) begin : g_pair
    assign dout_o[8*m +: 8] = din_i[16*m +: 8] + din_i[16*m+8 +: 8];
  end
endmodule

// File: rtl/mskpk_consec.sv
module mskpk_consec #(
  parameter int unsigned VEC_BYTES = 16
) (
  input  logic [4*VEC_BYTES*8-1:0] vecs_i,
  output logic [4*VEC_BYTES-1:0]   mask_o
);
  localparam int unsigned TOT_B  = 4 * VEC_BYTES;
  localparam int unsigned HALF_B = TOT_B / 2;
  localparam int unsigned QTR_B  = TOT_B / 4;

  logic [TOT_B*8-1:0] masked;
  logic [QTR_B*8-1:0] s1_lo, s1_hi, s2, s3;

  // one-hot bit per byte, chosen by position mod 8
  for (genvar g = 0; g < TOT_B; g++) begin : g_mask
    localparam logic [7:0] SEL = 8'h01 << (g % 8);
    assign masked[8*g +: 8] = vecs_i[8*g +: 8] & SEL;
  end

  mskpk_pair_add #(.OUT_BYTES(QTR_B)) i_stage1_lo (
    .din_i  (masked[HALF_B*8-1:0]),
    .dout_o (s1_lo)
  );
  mskpk_pair_add #(.OUT_BYTES(QTR_B)) i_stage1_hi (
    .din_i  (masked[TOT_B*8-1:HALF_B*8]),
    .dout_o (s1_hi)
  );
  mskpk_pair_add #(.OUT_BYTES(QTR_B)) i_stage2 (
    .din_i  ({s1_hi, s1_lo}),
    .dout_o (s2)
  );
  // last stage fed with a duplicate; the upper half is discarded
  mskpk_pair_add #(.OUT_BYTES(QTR_B)) i_stage3 (
    .din_i  ({s2, s2}),
    .dout_o (s3)
  );

  assign mask_o = s3[TOT_B-1:0];
endmodule

// File: rtl/mskpk_ilv.sv
module mskpk_ilv #(
  parameter int unsigned VEC_BYTES = 16
) (
  input  logic [4*VEC_BYTES*8-1:0] vecs_i,
  output logic [4*VEC_BYTES-1:0]   mask_o
);
  localparam int unsigned VEC_W = VEC_BYTES * 8;

  logic [VEC_W-1:0] acc;

  // vector r keeps bit r on even lanes, bit r+4 on odd lanes
  for (genvar l = 0; l < VEC_BYTES; l++) begin : g_lane
    localparam int unsigned SH = (l % 2) * 4;
    localparam logic [7:0] P0 = 8'h01 << SH;
    localparam logic [7:0] P1 = 8'h02 << SH;
    localparam logic [7:0] P2 = 8'h04 << SH;
    localparam logic [7:0] P3 = 8'h08 << SH;
    assign acc[8*l +: 8] = (vecs_i[0*VEC_W + 8*l +: 8] & P0)
                         | (vecs_i[1*VEC_W + 8*l +: 8] & P1)
                         | (vecs_i[2*VEC_W + 8*l +: 8] & P2)
                         | (vecs_i[3*VEC_W + 8*l +: 8] & P3);
  end

  mskpk_pair_add #(.OUT_BYTES(VEC_BYTES/2)) i_narrow (
    .din_i  (acc),
    .dout_o (mask_o)
  );
endmodule

// File: rtl/mskpk_top.sv
module mskpk_top
  import mskpk_pkg::*;
#(
  parameter int unsigned VEC_BYTES = 16,
  localparam int unsigned VEC_W    = VEC_BYTES * BYTE_W,
  localparam int unsigned MASK_W   = NUM_VEC * VEC_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              layout_i,
  input  logic [VEC_W-1:0]  vec0_i,
  input  logic [VEC_W-1:0]  vec1_i,
  input  logic [VEC_W-1:0]  vec2_i,
  input  logic [VEC_W-1:0]  vec3_i,
  output logic              valid_o,
  output logic [MASK_W-1:0] mask_o
);
  logic [NUM_VEC*VEC_W-1:0] vecs;
  logic [MASK_W-1:0]        consec_mask, ilv_mask, next_mask;
  layout_e                  layout;

  assign vecs   = {vec3_i, vec2_i, vec1_i, vec0_i};
  assign layout = layout_e'(layout_i);

  mskpk_consec #(.VEC_BYTES(VEC_BYTES)) i_consec (
    .vecs_i (vecs),
    .mask_o (consec_mask)
  );

  mskpk_ilv #(.VEC_BYTES(VEC_BYTES)) i_ilv (
    .vecs_i (vecs),
    .mask_o (ilv_mask)
  );

  always_comb begin
    unique case (layout)
      LAYOUT_ILV: next_mask = ilv_mask;
      default:    next_mask = consec_mask;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      mask_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) mask_o <= next_mask;
    end
  end

  function automatic int unsigned true_bytes(input logic [NUM_VEC*VEC_W-1:0] v);
    int unsigned n = 0;
    for (int b = 0; b < NUM_VEC*VEC_BYTES; b++) if (v[8*b +: 8] == 8'hFF) n++;
    return n;
  endfunction

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) reset_state_chk: assert (valid_o == 1'b0 && mask_o == '0);
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R2
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  // R3
  hold_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(mask_o));

  // R4: byte 1 of vector 1 lands on bit 17
  consec_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && layout_i == 1'b0) |=> (mask_o[17] == $past(vec1_i[8])));

  // R5: byte 1 of vector 2 lands on bit 6
  ilv_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && layout_i == 1'b1) |=> (mask_o[6] == $past(vec2_i[8])));

  // R6
  popcount_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ($countones(mask_o) == $past(true_bytes(vecs))));

  // R7
  all_true_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (&vecs)) |=> (&mask_o));
endmodule

// File: tb/test_mskpk_top.sv
`timescale 1ns/1ps
module test_mskpk_top;
  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         valid_i;
  logic         layout_i;
  logic [127:0] vec [4];
  logic         valid_o;
  logic [63:0]  mask_o;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 0;

  logic        exp_valid;
  logic [63:0] exp_mask;
  string       exp_tag;

  always #2 clk_i = ~clk_i;

  mskpk_top i_mskpk_top (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .layout_i (layout_i),
    .vec0_i   (vec[0]),
    .vec1_i   (vec[1]),
    .vec2_i   (vec[2]),
    .vec3_i   (vec[3]),
    .valid_o  (valid_o),
    .mask_o   (mask_o)
  );

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      failures++;
      $display("FAIL R2 watchdog expired: actual=hung expected=finished");
      report();
      $finish;
    end
  end

  // behavioural reference: byte k of the block -> bit k
  function automatic logic [63:0] ref_mask(input logic lay, input logic [127:0] v [4]);
    logic [63:0] m = '0;
    for (int k = 0; k < 64; k++) begin
      logic [7:0] b;
      if (lay) b = v[k % 4][8*(k/4) +: 8];
      else     b = v[k / 16][8*(k%16) +: 8];
      m[k] = (b == 8'hFF);
    end
    return m;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare current outputs, then drive the next cycle's inputs
  task automatic step(input logic vld, input logic lay, input logic [127:0] v [4], input string tag);
    @(negedge clk_i);
    check("R2 valid_o", 64'(valid_o), 64'(exp_valid));
    check(exp_tag, mask_o, exp_mask);
    if (exp_valid) check("R6 popcount", 64'($countones(mask_o)), 64'($countones(exp_mask)));
    valid_i  = vld;
    layout_i = lay;
    for (int i = 0; i < 4; i++) vec[i] = v[i];
    exp_valid = vld;
    if (vld) begin
      exp_mask = ref_mask(lay, v);
      exp_tag  = tag;
    end else begin
      exp_tag = "R3 hold";
    end
  endtask

  function automatic void from_bits(input logic lay, input logic [63:0] p, output logic [127:0] v [4]);
    for (int i = 0; i < 4; i++) v[i] = '0;
    for (int k = 0; k < 64; k++) begin
      if (lay) v[k % 4][8*(k/4) +: 8] = {8{p[k]}};
      else     v[k / 16][8*(k%16) +: 8] = {8{p[k]}};
    end
  endfunction

  function automatic void rand_vecs(output logic [127:0] v [4]);
    for (int i = 0; i < 4; i++)
      for (int b = 0; b < 16; b++) v[i][8*b +: 8] = {8{1'($urandom)}};
  endfunction

  initial begin
    logic [127:0] v [4];
    rst_ni   = 1'b0;
    valid_i  = 1'b0;
    layout_i = 1'b0;
    for (int i = 0; i < 4; i++) vec[i] = '0;
    exp_valid = 1'b0;
    exp_mask  = '0;
    exp_tag   = "R1 reset";
    repeat (3) @(negedge clk_i);
    check("R1 reset valid_o", 64'(valid_o), 64'd0);
    check("R1 reset mask_o", mask_o, 64'd0);
    rst_ni = 1'b1;

    for (int lay = 0; lay < 2; lay++) begin
      from_bits(1'(lay), 64'd0, v);
      step(1'b1, 1'(lay), v, "R7 all zero");
      from_bits(1'(lay), '1, v);
      step(1'b1, 1'(lay), v, "R7 all one");
    end

    for (int lay = 0; lay < 2; lay++)
      for (int k = 0; k < 64; k++) begin
        from_bits(1'(lay), 64'd1 << k, v);
        step(1'b1, 1'(lay), v, lay ? "R5 single" : "R4 single");
      end

    // idle cycles with moving data must not disturb the mask
    for (int n = 0; n < 8; n++) begin
      rand_vecs(v);
      step(1'b0, 1'(n % 2), v, "R3 hold");
    end

    for (int n = 0; n < 400; n++) begin
      logic lay = 1'(n % 2);
      rand_vecs(v);
      step(1'b1, lay, v, lay ? "R5 random" : "R4 random");
      if (n % 7 == 0) begin
        rand_vecs(v);
        step(1'b0, ~lay, v, "R3 hold");
      end
    end

    from_bits(1'b0, 64'd0, v);
    step(1'b0, 1'b0, v, "R3 hold");
    step(1'b0, 1'b0, v, "R3 hold");
    done = 1;
    report();
    $finish;
  end
endmodule